// File: doc/BRIEF.md
# SPI Master with Rate Prescaler

This block is a single-byte SPI master with a small three-address register port. Software programs a control word (enable, master select, idle level of the serial clock, sampling phase and a two-bit rate field) and a status word whose bit 0 is a double-speed select. Writing a byte to the data address starts a full-duplex exchange of eight bits. The block drives the serial clock and the outgoing data line and samples the incoming line. When the exchange ends, the received byte can be read back from the data address.

The serial clock is derived from the system clock. A three-bit code {double-speed, rate[1:0]} selects the divisor: codes 0 to 3 divide by 4, 16, 64 and 128, and codes 4 to 7 divide by 2, 8, 32 and 64. An active-low select input acts as a guard. If the select input is pulled low while the block is master, the block stops the exchange and leaves master mode. It stays out of master mode until software sets master select again.

Register map: address 0 is the control word, address 1 the status word and address 2 the data register. Control bits are bit 0 enable, bit 1 master, bit 2 clock polarity, bit 3 clock phase and bits 5:4 the rate field; bits 7:6 read as 0. Status bits are bit 7 transfer complete, bit 6 write collision and bit 0 double speed, which is the only writable status bit. Reads return data one cycle after the read strobe.

Top module: `spi_rate_master`

## Requirements
- R1: While enable (control bit 0) is 0, SCK sits at the level of clock polarity (control bit 2) and MOSI is 0, one cycle after the setting takes effect. At the end of each transfer, SCK returns to that idle level.
- R2: Each SCK half-period lasts D/2 system clocks, where D is 4, 16, 64 or 128 for codes 0 to 3 of {status bit 0, control bits 5:4}, and 2, 8, 32 or 64 for codes 4 to 7.
- R3: With clock phase (control bit 3) at 0, the first data bit is on MOSI before the leading SCK edge. Both sides sample on leading edges and change data on trailing edges.
- R4: With clock phase at 1, data changes on leading SCK edges and both sides sample on trailing edges.
- R5: Bits are shifted MSB first, with 16 SCK edges per byte. At the end, the received byte can be read at address 2 and status bit 7 is set.
- R6: A data write starts a transfer only when both enable and master (control bit 1) are 1. With master at 0, SCK stays at its idle level whatever the rate code.
- R7: A data write during a transfer does not change the byte being sent and sets status bit 6. A transfer with no such write leaves bit 6 at 0.
- R8: If the select input is low while enable and master are 1, master is cleared, status bit 7 is set and SCK goes back to idle. No transfer starts until master is written to 1 again.
- R9: Status bits 7 and 6 are cleared only by a status read that sees bit 7 set, followed by a read or write of address 2. An access to address 2 without that earlier status read leaves them set.
- R10: The status word reads bit 7 transfer complete, bit 6 write collision and bit 0 double speed. Bits 5:1 always read 0.
- R11: After reset, every register reads 0 and SCK and MOSI are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Read data, valid the cycle after bus_rd |
| ss_n_in | input | 1 | Active-low select guard; low while master is a mode fault |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |

## Verification
A pin-level slave model exchanges bytes in all four clock modes at every one of the eight divider codes and times each SCK half-period in system clocks. A wrong divisor shows up as a bad gap, and a swapped phase shows up as a corrupted byte on one side. Directed cases target the cases most likely to go wrong. A collision write that overwrites the shift register would corrupt the byte the slave receives. A mode fault that left master set would let a later data write start SCK. A clear sequence that ignores the earlier status read would drop the flag too early. A reserved status bit that is writable would show up on readback.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CTL_EN   = 0;
  localparam int CTL_MSTR = 1;
  localparam int CTL_CPOL = 2;
  localparam int CTL_CPHA = 3;
  localparam int CTL_RATE = 4;

  localparam int STA_DBL  = 0;

  typedef struct packed {
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       mstr;
    logic       en;
  } ctrl_t;

  // SCK half-period in system clocks for code {dbl, rate}
  function automatic logic [7:0] half_period(input logic [2:0] code);
    logic [7:0] base;
    if (code[1:0] == 2'd3) base = 8'd64;
    else                   base = 8'd2 << {code[1:0], 1'b0};
    if (code[2]) base = base >> 1;
    return base;
  endfunction

endpackage

// File: rtl/spi_rate_baud.sv
module spi_rate_baud #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == half - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/spi_rate_shift.sv
module spi_rate_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          abort,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          start,
  input  logic [DW-1:0] tx_in,
  input  logic          tick,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_out
);

  localparam int EW = $clog2(2 * DW);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DW - 1);

  logic [EW-1:0] ecnt;
  logic          tog;
  logic [DW-1:0] tx_sr;
  logic [DW-1:0] rx_sr;
  logic          samp;
  logic          last;

  // even edge index = leading edge; sample on leading when cpha = 0
  assign samp   = (ecnt[0] == cpha);
  assign last   = (ecnt == LAST_EDGE);
  assign rx_out = rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt  <= '0;
      tog   <= 1'b0;
      tx_sr <= '0;
      rx_sr <= '0;
      sck   <= 1'b0;
      mosi  <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en || abort) begin
        busy <= 1'b0;
        ecnt <= '0;
        tog  <= 1'b0;
        sck  <= cpol;
        if (!en) mosi <= 1'b0;
      end else if (!busy) begin
        sck <= cpol;
        tog <= 1'b0;
        if (start) begin
          busy <= 1'b1;
          ecnt <= '0;
          if (cpha) begin
            tx_sr <= tx_in;
          end else begin
            mosi  <= tx_in[DW-1];
            tx_sr <= {tx_in[DW-2:0], 1'b0};
          end
        end
      end else if (tick) begin
        tog  <= ~tog;
        sck  <= cpol ^ ~tog;
        ecnt <= ecnt + EW'(1);
        if (samp) begin
          rx_sr <= {rx_sr[DW-2:0], miso};
        end else if (!(last && !cpha)) begin
          mosi  <= tx_sr[DW-1];
          tx_sr <= {tx_sr[DW-2:0], 1'b0};
        end
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_rate_regs.sv
module spi_rate_regs
  import spi_rate_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          fault,
  input  logic          xfer_done,
  input  logic [DW-1:0] rx_in,
  input  logic          busy,
  output ctrl_t         ctrl,
  output logic          dbl,
  output logic          start,
  output logic          flag_done,
  output logic          flag_wcol,
  output logic [DW-1:0] bus_rdata
);

  logic armed;
  logic [DW-1:0] rx_q;
  logic wr_data;
  logic data_acc;

  assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
  assign data_acc = (bus_wr || bus_rd) && (bus_addr == ADDR_DATA);
  assign start    = wr_data && ctrl.en && ctrl.mstr && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      dbl       <= 1'b0;
      flag_done <= 1'b0;
      flag_wcol <= 1'b0;
      armed     <= 1'b0;
      rx_q      <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == ADDR_CTRL) begin
        ctrl.en   <= bus_wdata[CTL_EN];
        ctrl.mstr <= bus_wdata[CTL_MSTR];
        ctrl.cpol <= bus_wdata[CTL_CPOL];
        ctrl.cpha <= bus_wdata[CTL_CPHA];
        ctrl.rate <= bus_wdata[CTL_RATE+1:CTL_RATE];
      end
      if (fault) ctrl.mstr <= 1'b0;

      if (bus_wr && bus_addr == ADDR_STAT) dbl <= bus_wdata[STA_DBL];

      if (bus_rd && bus_addr == ADDR_STAT && flag_done) armed <= 1'b1;
      if (data_acc && armed) begin
        flag_done <= 1'b0;
        flag_wcol <= 1'b0;
        armed     <= 1'b0;
      end
      if (wr_data && busy) flag_wcol <= 1'b1;
      if (xfer_done) begin
        flag_done <= 1'b1;
        rx_q      <= rx_in;
      end
      if (fault) flag_done <= 1'b1;

      if (bus_rd) begin
        case (bus_addr)
          ADDR_CTRL: bus_rdata <= {{(DW-6){1'b0}}, ctrl.rate, ctrl.cpha,
                                   ctrl.cpol, ctrl.mstr, ctrl.en};
          ADDR_STAT: bus_rdata <= {flag_done, flag_wcol, {(DW-3){1'b0}}, dbl};
          ADDR_DATA: bus_rdata <= rx_q;
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_rate_master.sv
module spi_rate_master
  import spi_rate_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ss_n_in,
  input  logic          miso,
  output logic          sck,
  output logic          mosi
);

  ctrl_t            ctrl;
  logic             dbl;
  logic             start;
  logic             busy;
  logic             xfer_done;
  logic             flag_done;
  logic             flag_wcol;
  logic             fault;
  logic             tick;
  logic [DW-1:0]    rx_byte;
  logic [CNT_W-1:0] half;

  assign fault = ctrl.en && ctrl.mstr && !ss_n_in;
  assign half  = CNT_W'(half_period({dbl, ctrl.rate}));

  spi_rate_regs #(.DW(DW)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .fault     (fault),
    .xfer_done (xfer_done),
    .rx_in     (rx_byte),
    .busy      (busy),
    .ctrl      (ctrl),
    .dbl       (dbl),
    .start     (start),
    .flag_done (flag_done),
    .flag_wcol (flag_wcol),
    .bus_rdata (bus_rdata)
  );

  spi_rate_baud #(.CNT_W(CNT_W)) baud_i (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .half (half),
    .tick (tick)
  );

  spi_rate_shift #(.DW(DW)) shift_i (
    .clk    (clk),
    .rst    (rst),
    .en     (ctrl.en),
    .abort  (fault || !ctrl.mstr),
    .cpol   (ctrl.cpol),
    .cpha   (ctrl.cpha),
    .start  (start),
    .tx_in  (bus_wdata),
    .tick   (tick),
    .miso   (miso),
    .sck    (sck),
    .mosi   (mosi),
    .busy   (busy),
    .done   (xfer_done),
    .rx_out (rx_byte)
  );

endmodule

// File: rtl/spi_rate_master_chk.sv
module spi_rate_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       mstr,
  input logic       cpol,
  input logic       ss_n_in,
  input logic       sck,
  input logic       mosi,
  input logic       busy,
  input logic       xfer_done,
  input logic       flag_done,
  input logic       flag_wcol,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic [4:0] stat_mid
);

  // R1: disabled block parks SCK at polarity level, MOSI low
  assert_idle_level_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sck == $past(cpol) && !mosi));

  // R6: no SCK activity unless master
  assert_quiet_not_master_R6: assert property (@(posedge clk) disable iff (rst)
    !mstr |=> (sck == $past(cpol)));

  // R5: end of shifting raises the complete flag
  assert_done_flag_R5: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> flag_done);

  // R7: data write while busy flags a collision
  assert_collision_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd2 && busy) |=> flag_wcol);

  // R8: mode fault drops master, sets flag, stops the transfer
  assert_mode_fault_R8: assert property (@(posedge clk) disable iff (rst)
    (en && mstr && !ss_n_in) |=> (!mstr && flag_done && !busy));

  // R10: reserved status bits read zero
  assert_stat_reserved_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd1) |=> (stat_mid == 5'd0));

endmodule

bind spi_rate_master spi_rate_master_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .en        (ctrl.en),
  .mstr      (ctrl.mstr),
  .cpol      (ctrl.cpol),
  .ss_n_in   (ss_n_in),
  .sck       (sck),
  .mosi      (mosi),
  .busy      (busy),
  .xfer_done (xfer_done),
  .flag_done (flag_done),
  .flag_wcol (flag_wcol),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .stat_mid  (bus_rdata[5:1])
);

// File: tb/spi_rate_master_tb.sv
module spi_rate_master_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       ss_n_in;
  logic       miso;
  logic       sck, mosi;

  always #2 clk = ~clk;

  spi_rate_master dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ss_n_in(ss_n_in), .miso(miso), .sck(sck), .mosi(mosi)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int mon_cnt = 0;
  int tog_cnt = 0;
  bit finished = 0;

  typedef struct {
    bit         cpha;
    logic [7:0] slv;
    logic [7:0] mosi_exp;
    int         half;
  } item_t;

  item_t sb_q[$];
  event  item_ev;

  always @(posedge clk) cyc = cyc + 1;
  always @(sck) tog_cnt = tog_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  function automatic int half_of(input logic [2:0] c);
    int d;
    case (c[1:0])
      2'd0: d = 4;
      2'd1: d = 16;
      2'd2: d = 64;
      default: d = 128;
    endcase
    if (c[2]) d = d / 2;
    return d / 2;
  endfunction

  task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // Monitor: pin-level slave, pops expected items and compares
  initial begin
    item_t cur;
    logic [7:0] rx;
    int bad, last;
    miso = 1'b0;
    last = 0;
    forever begin
      @(item_ev);
      cur = sb_q.pop_front();
      if (!cur.cpha) miso = cur.slv[7];
      rx = '0;
      bad = 0;
      for (int e = 0; e < 16; e++) begin
        @(sck);
        if (e > 0 && (cyc - last) != cur.half) bad++;
        last = cyc;
        if (((e % 2) == 0) == !cur.cpha) rx = {rx[6:0], mosi};
        else if (cur.cpha) miso = cur.slv[7 - e/2];
        else if (e < 15) miso = cur.slv[7 - (e+1)/2];
      end
      chk(rx == cur.mosi_exp,
          cur.cpha ? "R4 slave byte MSB first, trailing-edge sample"
                   : "R3 slave byte MSB first, leading-edge sample",
          rx, cur.mosi_exp);
      chk(bad == 0, "R2 SCK half-period length", bad, 0);
      mon_cnt++;
    end
  end

  // Driver: one full exchange, pushing the expected item
  task automatic xfer(input bit cpol, input bit cpha, input logic [2:0] code,
                      input logic [7:0] tx, input logic [7:0] sl, input bit collide);
    item_t it;
    logic [7:0] st, rd;
    int n, m0;
    bwrite(2'd0, {2'b00, code[1:0], cpha, cpol, 2'b11});
    bwrite(2'd1, {7'b0, code[2]});
    it.cpha = cpha; it.slv = sl; it.mosi_exp = tx; it.half = half_of(code);
    m0 = mon_cnt;
    sb_q.push_back(it);
    -> item_ev;
    bwrite(2'd2, tx);
    if (collide) begin
      repeat (20) @(negedge clk);
      bwrite(2'd2, ~tx);
    end
    n = 0; st = '0;
    while (!st[7] && n < 5000) begin
      bread(2'd1, st);
      n++;
    end
    chk(st[7] == 1'b1, "R5 complete flag set", st[7], 1);
    chk(st[6] == collide, collide ? "R7 collision flag set" : "R7 collision flag clear",
        st[6], collide);
    chk(mon_cnt == m0 + 1, "R5 sixteen SCK edges observed", mon_cnt - m0, 1);
    bread(2'd2, rd);
    chk(rd == sl, cpha ? "R4 received byte" : "R3 received byte", rd, sl);
    bread(2'd1, st);
    chk(st[7:6] == 2'b00, "R9 flags cleared by status then data", st[7:6], 0);
    chk(sck == cpol, "R1 SCK back at idle level", sck, cpol);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] v;
    item_t it;
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; ss_n_in = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk(sck == 1'b0 && mosi == 1'b0, "R11 pins low after reset", {sck, mosi}, 0);
    bread(2'd0, v); chk(v == 8'h00, "R11 control reset", v, 8'h00);
    bread(2'd1, v); chk(v == 8'h00, "R11 status reset", v, 8'h00);
    bread(2'd2, v); chk(v == 8'h00, "R11 data reset", v, 8'h00);

    // R10 only bit 0 of status is writable
    bwrite(2'd1, 8'hFF);
    bread(2'd1, v); chk(v == 8'h01, "R10 status layout", v, 8'h01);
    bwrite(2'd1, 8'h00);

    // R1 idle level while disabled
    bwrite(2'd0, 8'h04);
    @(negedge clk);
    chk(sck == 1'b1 && mosi == 1'b0, "R1 disabled idle high", {sck, mosi}, 2'b10);
    bwrite(2'd0, 8'h00);
    @(negedge clk);
    chk(sck == 1'b0 && mosi == 1'b0, "R1 disabled idle low", {sck, mosi}, 2'b00);

    // R6 enabled but not master: no SCK at fastest code
    bwrite(2'd0, 8'h01);
    bwrite(2'd1, 8'h01);
    tog_cnt = 0;
    bwrite(2'd2, 8'h55);
    repeat (100) @(negedge clk);
    chk(tog_cnt == 0, "R6 no SCK edges when not master", tog_cnt, 0);
    bread(2'd1, v); chk(v[7] == 1'b0, "R6 no completion when not master", v[7], 0);

    // R2/R3/R4/R5 every mode at every divider code
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 8; c++) begin
        xfer(m[1], m[0], c[2:0], 8'((m*8 + c) * 29 + 8'h5A),
             8'((m*8 + c) * 53 + 8'hC3), 1'b0);
      end
    end
    xfer(1'b0, 1'b0, 3'd4, 8'hFF, 8'h00, 1'b0);
    xfer(1'b1, 1'b1, 3'd4, 8'h00, 8'hFF, 1'b0);

    // R7 write collision: byte on the line unchanged
    xfer(1'b0, 1'b1, 3'd3, 8'h96, 8'h69, 1'b1);

    // R9 data access without prior status read keeps the flag
    bwrite(2'd0, 8'h03);
    bwrite(2'd1, 8'h01);
    it.cpha = 1'b0; it.slv = 8'hB4; it.mosi_exp = 8'h2D; it.half = 1;
    sb_q.push_back(it);
    -> item_ev;
    bwrite(2'd2, 8'h2D);
    repeat (60) @(negedge clk);
    bread(2'd2, v); chk(v == 8'hB4, "R5 received byte at fastest code", v, 8'hB4);
    bread(2'd1, v); chk(v == 8'h81, "R9 flag kept without status read first", v, 8'h81);
    bread(2'd2, v);
    bread(2'd1, v); chk(v == 8'h01, "R9 flag cleared after status then data", v, 8'h01);

    // R8 mode fault mid-transfer
    bwrite(2'd0, 8'h13);
    bwrite(2'd1, 8'h00);
    bwrite(2'd2, 8'hF0);
    repeat (28) @(negedge clk);
    ss_n_in = 1'b0;
    repeat (3) @(negedge clk);
    ss_n_in = 1'b1;
    @(negedge clk);
    chk(sck == 1'b0, "R8 SCK idle after fault", sck, 0);
    bread(2'd0, v); chk(v == 8'h11, "R8 master cleared by fault", v, 8'h11);
    bread(2'd1, v); chk(v[7] == 1'b1, "R8 complete flag set by fault", v[7], 1);
    tog_cnt = 0;
    bwrite(2'd2, 8'h0F);
    repeat (100) @(negedge clk);
    chk(tog_cnt == 0, "R8 no transfer until master rewritten", tog_cnt, 0);
    xfer(1'b0, 1'b0, 3'd4, 8'h3C, 8'hC3, 1'b0);

    // R1 disabling forces MOSI low after a byte ending in 1
    xfer(1'b1, 1'b0, 3'd4, 8'h01, 8'h80, 1'b0);
    bwrite(2'd0, 8'h04);
    @(negedge clk);
    chk(sck == 1'b1 && mosi == 1'b0, "R1 disable parks pins", {sck, mosi}, 2'b10);

    report();
  end

endmodule